// File: doc/BRIEF.md
# FM synth timer and status unit

This block provides the two interval timers and the status/interrupt logic of a classic FM sound generator. A host reaches it through a byte-wide register port. A write with the select line low stores a register index. A write with the select line high stores a data byte into the register that index names. Two 8-bit preload registers and one control register configure two up-counting timers. The first timer advances once per 80 us and the second once per 320 us. Both tick rates come from the system clock through prescalers whose divide ratios are computed from parameters.

The status byte is always visible on an output port. It carries an interrupt summary bit, one sticky overflow flag per timer, and a fixed variant signature in its low bits. The interrupt output follows the summary bit. A timer that overflows reloads its preload value and keeps running. A per-timer mask keeps that timer from ever raising its flag. A dedicated control bit clears every flag without disturbing the timers. Host software uses this to probe for the device and to get periodic interrupts at multiples of 80 us or 320 us.

Top module: `fmt_timer_unit`

## Requirements
- R1: After reset, status bits 7..5 read 000, `irq_o` is low, and status bits 4..3 read 00.
- R2: A write with `bus_sel`=0 stores an index. A write with `bus_sel`=1 stores data into the register the index names: 0x02 is the timer-1 preload, 0x03 is the timer-2 preload, 0x04 is the control register. Data written under any other index changes nothing.
- R3: Control bit 0 starts timer 1. When it goes from 0 to 1, the counter loads the timer-1 preload P. With timer 1 unmasked, its flag (status bit 6) sets exactly (256-P)×DIV1 clock cycles after the write edge, where DIV1 = T1_PERIOD_NS×CLK_FREQ_HZ/1e9 (80 us by default).
- R4: Control bit 1 starts timer 2 in the same way. Its flag (status bit 5) sets exactly (256-P)×DIV2 cycles after the start, with DIV2 derived from T2_PERIOD_NS (320 us by default).
- R5: Status bit 7 is the OR of the two flags. A flag, once set, stays set until an IRQ reset.
- R6: Control bit 6 masks timer 1 and bit 5 masks timer 2. A masked timer never sets its flag.
- R7: A control write with bit 7 set clears both flags. All other bits of that write are ignored: the start and mask bits and the running timers are untouched.
- R8: On overflow, a counter reloads its preload and keeps counting, so an unmasked flag would set again every (256-P) ticks.
- R9: Clearing a start bit stops that counter and holds it. A later 0-to-1 start reloads the preload. Rewriting a start bit that is already 1 does not restart the timer.
- R10: `irq_o` is active high and always equals status bit 7.
- R11: Status bits 2..0 read 0x6 when TWO_OP=1 and 0x0 when TWO_OP=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per high cycle |
| bus_sel | input | 1 | 0 = index byte, 1 = data byte |
| bus_wdata | input | 8 | Byte being written |
| status_o | output | 8 | Status byte: summary, two flags, signature |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The embedded assertions check several properties on every cycle:
- a masked timer cannot raise its flag, and flags are sticky until a clear;
- a clear empties both flags and leaves the control bits alone;
- an overflow reloads the counter, and a stopped counter does not move;
- the prescaler stays within its ratio.

The directed scenarios are the only way to show the exact overflow cycle counts for each timer and preload, and the register index decoding. They also show that a restart reloads rather than resumes, that rewriting a running start bit changes nothing, and that the signature tracks its parameter. The bench shortens the two tick periods through parameters, keeping their 1:4 ratio, so several full periods fit into one run.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    localparam int CNT_W = 8;

    // register indexes selected by the host
    localparam logic [7:0] IDX_PRE1 = 8'h02;
    localparam logic [7:0] IDX_PRE2 = 8'h03;
    localparam logic [7:0] IDX_CTRL = 8'h04;

    // control byte bit positions
    localparam int CB_CLR   = 7;
    localparam int CB_MASK1 = 6;
    localparam int CB_MASK2 = 5;
    localparam int CB_RUN2  = 1;
    localparam int CB_RUN1  = 0;

    typedef struct packed {
        logic mask1;
        logic mask2;
        logic run1;
        logic run2;
    } ctrl_t;

endpackage

// File: rtl/fmt_hostport.sv
module fmt_hostport
    import fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_sel,
    input  logic [7:0]       bus_wdata,
    output logic [CNT_W-1:0] pre1_o,
    output logic [CNT_W-1:0] pre2_o,
    output ctrl_t            ctrl_o,
    output logic             load1_o,
    output logic             load2_o,
    output logic             clr_o
);

    typedef struct packed {
        logic [7:0]       idx;
        logic [CNT_W-1:0] pre1;
        logic [CNT_W-1:0] pre2;
        ctrl_t            ctrl;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     load1_d, load2_d, clr_d;

    always_comb begin
        st_d    = st_q;
        load1_d = 1'b0;
        load2_d = 1'b0;
        clr_d   = 1'b0;
        if (bus_wr && !bus_sel) begin
            st_d.idx = bus_wdata;
        end else if (bus_wr && bus_sel) begin
            case (st_q.idx)
                IDX_PRE1: st_d.pre1 = bus_wdata[CNT_W-1:0];
                IDX_PRE2: st_d.pre2 = bus_wdata[CNT_W-1:0];
                IDX_CTRL: begin
                    if (bus_wdata[CB_CLR]) begin
                        clr_d = 1'b1;
                    end else begin
                        st_d.ctrl.mask1 = bus_wdata[CB_MASK1];
                        st_d.ctrl.mask2 = bus_wdata[CB_MASK2];
                        st_d.ctrl.run1  = bus_wdata[CB_RUN1];
                        st_d.ctrl.run2  = bus_wdata[CB_RUN2];
                        load1_d = bus_wdata[CB_RUN1] && !st_q.ctrl.run1;
                        load2_d = bus_wdata[CB_RUN2] && !st_q.ctrl.run2;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pre1_o  = st_q.pre1;
    assign pre2_o  = st_q.pre2;
    assign ctrl_o  = st_q.ctrl;
    assign load1_o = load1_d;
    assign load2_o = load2_d;
    assign clr_o   = clr_d;

    AST_CLR_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> $stable(st_q.ctrl)); // R7

endmodule

// File: rtl/fmt_ticker.sv
module fmt_ticker
    import fmt_pkg::*;
#(
    parameter int DIV = 20000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] preload_i,
    output logic             ovf_o
);

    localparam int              PW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0]   LAST = PW'(DIV - 1);
    localparam logic [CNT_W-1:0] TOP = '1;

    typedef struct packed {
        logic [PW-1:0]    presc;
        logic [CNT_W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     ovf_d;

    always_comb begin
        st_d  = st_q;
        ovf_d = 1'b0;
        if (load_i) begin
            st_d.presc = '0;
            st_d.cnt   = preload_i;
        end else if (run_i) begin
            if (st_q.presc == LAST) begin
                st_d.presc = '0;
                if (st_q.cnt == TOP) begin
                    st_d.cnt = preload_i;
                    ovf_d    = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end else begin
                st_d.presc = st_q.presc + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_o = ovf_d;

    AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.presc <= LAST); // R3

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (st_q.cnt == $past(preload_i))); // R8

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> ($stable(st_q.cnt) && $stable(st_q.presc))); // R9

endmodule

// File: rtl/fmt_flags.sv
module fmt_flags #(
    parameter bit TWO_OP = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf1_i,
    input  logic       ovf2_i,
    input  logic       mask1_i,
    input  logic       mask2_i,
    input  logic       clr_i,
    output logic [7:0] status_o,
    output logic       irq_o
);

    localparam logic [2:0] SIG = TWO_OP ? 3'b110 : 3'b000;

    typedef struct packed {
        logic f1;
        logic f2;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (ovf1_i && !mask1_i) st_d.f1 = 1'b1;
            if (ovf2_i && !mask2_i) st_d.f2 = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o    = st_q.f1 | st_q.f2;
    assign status_o = {irq_o, st_q.f1, st_q.f2, 2'b00, SIG};

    AST_MASK_BLOCKS_T1: assert property (@(posedge clk) disable iff (!rst_n)
        (mask1_i && !st_q.f1) |=> !st_q.f1); // R6

    AST_MASK_BLOCKS_T2: assert property (@(posedge clk) disable iff (!rst_n)
        (mask2_i && !st_q.f2) |=> !st_q.f2); // R6

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!st_q.f1 && !st_q.f2)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.f1 && !clr_i) |=> st_q.f1); // R5

    AST_SET_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.f2) |-> $past(ovf2_i)); // R4

endmodule

// File: rtl/fmt_timer_unit.sv
module fmt_timer_unit
    import fmt_pkg::*;
#(
    parameter longint CLK_FREQ_HZ  = 250_000_000,
    parameter longint T1_PERIOD_NS = 80_000,
    parameter longint T2_PERIOD_NS = 320_000,
    parameter bit     TWO_OP       = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] status_o,
    output logic       irq_o
);

    localparam int DIV1 = int'(T1_PERIOD_NS * CLK_FREQ_HZ / 64'd1_000_000_000);
    localparam int DIV2 = int'(T2_PERIOD_NS * CLK_FREQ_HZ / 64'd1_000_000_000);

    logic [CNT_W-1:0] pre1, pre2;
    ctrl_t            ctrl;
    logic             load1, load2, clr;
    logic             ovf1, ovf2;

    fmt_hostport u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .pre1_o    (pre1),
        .pre2_o    (pre2),
        .ctrl_o    (ctrl),
        .load1_o   (load1),
        .load2_o   (load2),
        .clr_o     (clr)
    );

    fmt_ticker #(.DIV(DIV1)) u_tick1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl.run1),
        .load_i    (load1),
        .preload_i (pre1),
        .ovf_o     (ovf1)
    );

    fmt_ticker #(.DIV(DIV2)) u_tick2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl.run2),
        .load_i    (load2),
        .preload_i (pre2),
        .ovf_o     (ovf2)
    );

    fmt_flags #(.TWO_OP(TWO_OP)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf1_i   (ovf1),
        .ovf2_i   (ovf2),
        .mask1_i  (ctrl.mask1),
        .mask2_i  (ctrl.mask2),
        .clr_i    (clr),
        .status_o (status_o),
        .irq_o    (irq_o)
    );

endmodule

// File: tb/test_fmt_timer_unit.sv
`timescale 1ns/1ps
module test_fmt_timer_unit;

    localparam longint T1_NS = 400;
    localparam longint T2_NS = 1600;
    localparam int     D1    = int'(T1_NS / 4);   // 4 ns clock
    localparam int     D2    = int'(T2_NS / 4);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] status_o, status4;
    logic       irq_o, irq4;
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fmt_timer_unit #(.T1_PERIOD_NS(T1_NS), .T2_PERIOD_NS(T2_NS), .TWO_OP(1'b1)) i_fmt_timer_unit (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .status_o(status_o), .irq_o(irq_o)
    );

    fmt_timer_unit #(.T1_PERIOD_NS(T1_NS), .T2_PERIOD_NS(T2_NS), .TWO_OP(1'b0)) i_fmt_timer_unit_four (
        .clk(clk), .rst_n(rst_n), .bus_wr(1'b0), .bus_sel(1'b0),
        .bus_wdata(8'h00), .status_o(status4), .irq_o(irq4)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual 0x%02h expected 0x%02h", req, cyc, act, exp);
        end
    endtask

    task automatic wr_byte(input logic sel, input logic [7:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] data);
        wr_byte(1'b0, idx);
        wr_byte(1'b1, data);
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic top_bits(input string req, input logic [2:0] exp);
        chk(req, {5'd0, status_o[7:5]}, {5'd0, exp});
        chk({req, " irq"}, {7'd0, irq_o}, {7'd0, status_o[7]});   // R10
    endtask

    // R1 and R11: reset state of both variants
    task automatic t_reset;
        chk("R1 status after reset", status_o, 8'h06);
        chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);
        chk("R11 four-op signature", status4, 8'h00);
        chk("R11 four-op irq", {7'd0, irq4}, 8'h00);
    endtask

    // R3, R5, R10: probe sequence with preload 0xFF
    task automatic t_probe;
        int t0;
        wr_reg(8'h02, 8'hFF);
        wr_reg(8'h04, 8'h80);
        wr_reg(8'h04, 8'h21);
        t0 = cyc;
        wait_to(t0 + D1 - 1);
        top_bits("R3 probe before one tick", 3'b000);
        wait_to(t0 + D1);
        top_bits("R3 probe after one tick", 3'b110);
        chk("R5 full status", status_o, 8'hC6);
        wr_reg(8'h04, 8'h60);
        wr_reg(8'h04, 8'h80);
        chk("R7 status after clear", status_o, 8'h06);
        chk("R10 irq after clear", {7'd0, irq_o}, 8'h00);
    endtask

    // R3, R7, R8: four-tick period, clear with extra bits, reload
    task automatic t_reload;
        int t0;
        wr_reg(8'h02, 8'hFC);
        wr_reg(8'h04, 8'h21);
        t0 = cyc;
        wait_to(t0 + 4*D1 - 1);
        top_bits("R3 four ticks, one cycle early", 3'b000);
        wait_to(t0 + 4*D1);
        top_bits("R3 four ticks", 3'b110);
        wr_reg(8'h04, 8'hE3);   // clear; other bits must be ignored
        top_bits("R7 flags cleared", 3'b000);
        wait_to(t0 + 8*D1 - 1);
        top_bits("R8 second period, one cycle early", 3'b000);
        wait_to(t0 + 8*D1);
        top_bits("R8 R7 second period after clear", 3'b110);
    endtask

    // R4: timer 2 with preload 0xFE
    task automatic t_timer2;
        int t0;
        wr_reg(8'h04, 8'h60);
        wr_reg(8'h04, 8'h80);
        wr_reg(8'h03, 8'hFE);
        wr_reg(8'h04, 8'h42);
        t0 = cyc;
        wait_to(t0 + 2*D2 - 1);
        top_bits("R4 timer2 one cycle early", 3'b000);
        wait_to(t0 + 2*D2);
        top_bits("R4 timer2 overflow", 3'b101);
    endtask

    // R6: both timers running but masked
    task automatic t_masked;
        int t0;
        wr_reg(8'h04, 8'h60);
        wr_reg(8'h04, 8'h80);
        wr_reg(8'h02, 8'hFF);
        wr_reg(8'h04, 8'h63);
        t0 = cyc;
        wait_to(t0 + 3*D2);
        top_bits("R6 masked timers raise nothing", 3'b000);
        wr_reg(8'h04, 8'h60);
    endtask

    // R9, R2: stop holds, restart reloads, rewrite does not restart, stray index ignored
    task automatic t_stop_restart;
        int t0, t1;
        wr_reg(8'h02, 8'hFC);
        wr_reg(8'h04, 8'h21);
        t0 = cyc;
        wait_to(t0 + 2*D1);
        wr_reg(8'h04, 8'h20);
        wait_to(t0 + 6*D1);
        top_bits("R9 stopped timer does not overflow", 3'b000);
        wr_reg(8'h04, 8'h21);
        t1 = cyc;
        wait_to(t1 + D1);
        wr_reg(8'h05, 8'h00);   // R2: unknown index must not touch control
        wait_to(t1 + 2*D1);
        wr_reg(8'h04, 8'h21);   // R9: start already set, no restart
        wait_to(t1 + 4*D1 - 1);
        top_bits("R9 R2 restart reloads, one cycle early", 3'b000);
        wait_to(t1 + 4*D1);
        top_bits("R9 R2 restart reloads, full period", 3'b110);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_probe();
        t_reload();
        t_timer2();
        t_masked();
        t_stop_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule